// File: doc/BRIEF.md
# Per-Page Conflict-Miss Monitor

This block watches the stream of cache misses and keeps a separate miss count for each physical page it tracks. A page holds a fixed number of cache blocks. If a page misses far more often than it has blocks, the surplus cannot be first-touch misses, so the page is suffering conflict misses. When one tracked page's count reaches a programmable multiple of its block count, the block raises an interrupt and latches that page's number. Software can then move the page to a different cache colour and acknowledge the interrupt.

Tracking lives in a small fully associative table of page tags and saturating counters. A miss to an untracked page takes a free slot if one exists. Otherwise it evicts the slot with the smallest count. While one report is outstanding, other pages keep counting silently. Moving the page is left to software.

Top module: `page_miss_monitor`

## Requirements
- R1: After reset `irq` is 0, `irq_page` is 0, every table slot is empty and the threshold factor is 4.
- R2: Misses are counted per page, where the page number is `miss_addr[ADDR_W-1:PAGE_OFF_W]`. Misses to one page never add to another page's count, and at most one slot tracks a given page.
- R3: The threshold is (2^(PAGE_OFF_W-BLOCK_OFF_W)) blocks times the factor. With defaults that is 64 × factor. When a miss brings a page's count to the threshold or beyond, and no report is outstanding, `irq` is 1 and `irq_page` holds that page from the next clock edge. One miss fewer leaves `irq` at 0.
- R4: Once raised, `irq` stays 1 and `irq_page` stays unchanged until `irq_ack` is sampled high.
- R5: Sampling `irq_ack` high while `irq` is 1 drops `irq` at the next edge, unless R9 applies. It also clears the flagged page's counter to 0, so that page needs a full threshold of new misses to be reported again.
- R6: While a report is outstanding, other pages that cross the threshold are not reported, but their counts keep growing. After the acknowledge, such a page is reported on its next miss.
- R7: Counters saturate at 2^CNT_W-1 and never wrap.
- R8: A miss to an untracked page uses the lowest-numbered free slot. When the table is full, it evicts the slot with the smallest count, taking the lowest index on a tie. The new slot starts at a count of 1.
- R9: In a cycle with both `irq_ack` and a miss, the acknowledge is applied first. A miss to the flagged page restarts its count at 1. A miss that brings another page to the threshold is reported at once, so `irq` stays 1 and `irq_page` changes.
- R10: A cycle with `cfg_we` high loads `cfg_factor` as the new factor. The new factor applies to misses from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | One cache miss this cycle |
| miss_addr | input | ADDR_W | Physical address of the miss |
| cfg_we | input | 1 | Load a new threshold factor |
| cfg_factor | input | FACTOR_W | Threshold factor value |
| irq_ack | input | 1 | Software acknowledge of the report |
| irq | output | 1 | Conflict-miss interrupt, level |
| irq_page | output | ADDR_W-PAGE_OFF_W | Number of the reported page |

## Verification
An acknowledge and a miss can land in the same cycle, and the outcome depends on which page the miss hits. The bench drives `irq_ack` together with a miss on the flagged page and expects `irq` to fall and that page's count to restart at 1, which is then confirmed by counting misses to the next report. It also drives `irq_ack` together with a miss on a second page that is already past the threshold. There the scoreboard expects an immediate switch of `irq_page` with `irq` held high.

// File: rtl/pmm_pkg.sv
package pmm_pkg;
   parameter int unsigned PMM_DEF_FACTOR = 4;

   function automatic int unsigned pmm_thresh(input int unsigned blocks,
                                              input int unsigned factor);
      return blocks * factor;
   endfunction
endpackage

// File: rtl/pmm_entry.sv
module pmm_entry #(
   parameter int unsigned TAG_W = 20,
   parameter int unsigned CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             look_valid,
   input  logic [TAG_W-1:0] look_tag,
   input  logic             alloc_i,
   input  logic             clr_req,
   input  logic [TAG_W-1:0] clr_tag,
   output logic             match_o,
   output logic             valid_o,
   output logic [CNT_W-1:0] count_o,
   output logic [CNT_W-1:0] cnt_nxt_o
);
   logic             valid_q;
   logic [TAG_W-1:0] tag_q;
   logic [CNT_W-1:0] cnt_q, base, inc;
   logic             clr_hit, hit_upd;

   assign match_o = valid_q && (tag_q == look_tag);
   assign clr_hit = clr_req && valid_q && (tag_q == clr_tag);
   assign hit_upd = look_valid && match_o;

   always_comb begin
      base = clr_hit ? '0 : cnt_q;
      inc  = (&base) ? base : base + CNT_W'(1);
   end

   assign cnt_nxt_o = alloc_i ? CNT_W'(1) : inc;
   assign valid_o   = valid_q;
   assign count_o   = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         tag_q   <= '0;
         cnt_q   <= '0;
      end else if (alloc_i) begin
         valid_q <= 1'b1;
         tag_q   <= look_tag;
         cnt_q   <= CNT_W'(1);
      end else if (hit_upd) begin
         cnt_q <= inc;
      end else if (clr_hit) begin
         cnt_q <= '0;
      end
   end

   p_alloc_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_i |=> valid_q && cnt_q == CNT_W'(1) && tag_q == $past(look_tag));

   p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hit_upd && !alloc_i && !clr_hit && (&cnt_q) |=> (&cnt_q));

   p_ack_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clr_hit && !hit_upd && !alloc_i |=> cnt_q == '0);
endmodule

// File: rtl/pmm_victim.sv
module pmm_victim #(
   parameter int unsigned ENTRIES = 16,
   parameter int unsigned CNT_W   = 10,
   parameter int unsigned IDX_W   = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [ENTRIES-1:0]            valid_i,
   input  logic [ENTRIES-1:0][CNT_W-1:0] count_i,
   output logic [IDX_W-1:0]              victim_o
);
   logic             found;
   logic [CNT_W-1:0] best;

   always_comb begin
      victim_o = '0;
      found    = 1'b0;
      best     = count_i[0];
      for (int i = 0; i < ENTRIES; i++) begin
         if (!valid_i[i] && !found) begin
            victim_o = IDX_W'(i);
            found    = 1'b1;
         end
      end
      if (!found) begin
         for (int i = 1; i < ENTRIES; i++) begin
            if (count_i[i] < best) begin
               best     = count_i[i];
               victim_o = IDX_W'(i);
            end
         end
      end
   end

   p_victim_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(&valid_i) |-> !valid_i[victim_o]);

   for (genvar g = 0; g < ENTRIES; g++) begin : g_min_chk
      p_victim_min_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (&valid_i) |-> count_i[victim_o] <= count_i[g]);
   end
endmodule

// File: rtl/page_miss_monitor.sv
module page_miss_monitor
   import pmm_pkg::*;
#(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned PAGE_OFF_W  = 12,
   parameter int unsigned BLOCK_OFF_W = 6,
   parameter int unsigned ENTRIES     = 16,
   parameter int unsigned CNT_W       = 10,
   parameter int unsigned FACTOR_W    = 3,
   parameter int unsigned DEF_FACTOR  = PMM_DEF_FACTOR
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         miss_valid,
   input  logic [ADDR_W-1:0]            miss_addr,
   input  logic                         cfg_we,
   input  logic [FACTOR_W-1:0]          cfg_factor,
   input  logic                         irq_ack,
   output logic                         irq,
   output logic [ADDR_W-PAGE_OFF_W-1:0] irq_page
);
   localparam int unsigned PAGE_W = ADDR_W - PAGE_OFF_W;
   localparam int unsigned BLOCKS = 1 << (PAGE_OFF_W - BLOCK_OFF_W);
   localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   if (PAGE_OFF_W <= BLOCK_OFF_W) begin : g_bad_geometry
      $error("page offset must be wider than block offset");
   end
   if (ENTRIES < 2) begin : g_bad_entries
      $error("table needs at least two slots");
   end
   if (BLOCKS * ((1 << FACTOR_W) - 1) >= (1 << CNT_W)) begin : g_bad_cnt
      $error("counter too narrow for the largest threshold");
   end
   if (DEF_FACTOR >= (1 << FACTOR_W)) begin : g_bad_default
      $error("default factor does not fit FACTOR_W");
   end

   logic [FACTOR_W-1:0]             factor_q;
   logic                            irq_q;
   logic [PAGE_W-1:0]               flag_q;
   logic [PAGE_W-1:0]               look_page;
   logic [ENTRIES-1:0]              match_vec, valid_vec, alloc_vec;
   logic [ENTRIES-1:0][CNT_W-1:0]   cnt_vec, nxt_vec;
   logic [IDX_W-1:0]                victim;
   logic [CNT_W-1:0]                touched_cnt;
   logic [31:0]                     thr;
   logic                            hit, clr_req, report;
   logic                            unused_offset;

   assign look_page     = miss_addr[ADDR_W-1:PAGE_OFF_W];
   assign unused_offset = ^miss_addr[PAGE_OFF_W-1:0];
   assign hit           = |match_vec;
   assign clr_req       = irq_ack && irq_q;
   assign thr           = pmm_thresh(BLOCKS, 32'(factor_q));

   always_comb begin
      alloc_vec = '0;
      if (miss_valid && !hit) alloc_vec[victim] = 1'b1;
   end

   for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
      pmm_entry #(.TAG_W(PAGE_W), .CNT_W(CNT_W)) u_entry (
         .clk       (clk),
         .rst_n     (rst_n),
         .look_valid(miss_valid),
         .look_tag  (look_page),
         .alloc_i   (alloc_vec[e]),
         .clr_req   (clr_req),
         .clr_tag   (flag_q),
         .match_o   (match_vec[e]),
         .valid_o   (valid_vec[e]),
         .count_o   (cnt_vec[e]),
         .cnt_nxt_o (nxt_vec[e])
      );
   end

   pmm_victim #(.ENTRIES(ENTRIES), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_victim (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid_i (valid_vec),
      .count_i (cnt_vec),
      .victim_o(victim)
   );

   always_comb begin
      touched_cnt = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (match_vec[i] || alloc_vec[i]) touched_cnt = touched_cnt | nxt_vec[i];
      end
   end

   assign report = miss_valid && (!irq_q || irq_ack) && (32'(touched_cnt) >= thr);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         factor_q <= FACTOR_W'(DEF_FACTOR);
         irq_q    <= 1'b0;
         flag_q   <= '0;
      end else begin
         if (cfg_we) factor_q <= cfg_factor;
         if (report) begin
            irq_q  <= 1'b1;
            flag_q <= look_page;
         end else if (clr_req) begin
            irq_q <= 1'b0;
         end
      end
   end

   assign irq      = irq_q;
   assign irq_page = flag_q;

   p_one_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match_vec));

   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q && !irq_ack |=> irq_q);

   p_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q && !irq_ack |=> $stable(flag_q));

   p_ack_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q && irq_ack && !miss_valid |=> !irq_q);
endmodule

// File: tb/page_miss_monitor_bench.sv
`timescale 1ns/1ps
module page_miss_monitor_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        miss_valid = 1'b0;
   logic [31:0] miss_addr = '0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_factor = '0;
   logic        irq_ack = 1'b0;
   logic        irq;
   logic [19:0] irq_page;

   typedef struct {
      logic [19:0] pg;
      string       tag;
   } exp_t;

   exp_t        exp_q[$];
   int          nchk = 0;
   int          nfail = 0;
   bit          done = 1'b0;
   logic        irq_d = 1'b0;
   logic [19:0] page_d = '0;

   always #10 clk = ~clk;

   page_miss_monitor u_page_miss_monitor (
      .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
      .cfg_we(cfg_we), .cfg_factor(cfg_factor), .irq_ack(irq_ack),
      .irq(irq), .irq_page(irq_page)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint expv);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: got %0h expected %0h", tag, what, act, expv);
      end
   endtask

   task automatic expect_report(input logic [19:0] pg, input string tag);
      exp_t e;
      e.pg  = pg;
      e.tag = tag;
      exp_q.push_back(e);
   endtask

   // monitor: each new report must match the head of the queue
   always @(negedge clk) begin
      if (!rst_n) begin
         irq_d  <= 1'b0;
         page_d <= '0;
      end else begin
         if (irq && (!irq_d || irq_page != page_d)) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R6", "unexpected report", longint'(irq_page), 0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               chk(irq_page == e.pg, e.tag, "reported page",
                   longint'(irq_page), longint'(e.pg));
            end
         end
         irq_d  <= irq;
         page_d <= irq_page;
      end
   end

   task automatic do_miss(input logic [19:0] pg, input int n);
      for (int k = 0; k < n; k++) begin
         miss_valid = 1'b1;
         miss_addr  = {pg, 12'(k * 64)};
         @(negedge clk);
      end
      miss_valid = 1'b0;
   endtask

   task automatic do_ack();
      irq_ack = 1'b1;
      @(negedge clk);
      irq_ack = 1'b0;
   endtask

   task automatic ack_with_miss(input logic [19:0] pg);
      irq_ack    = 1'b1;
      miss_valid = 1'b1;
      miss_addr  = {pg, 12'h040};
      @(negedge clk);
      irq_ack    = 1'b0;
      miss_valid = 1'b0;
   endtask

   task automatic set_factor(input logic [2:0] f);
      cfg_we     = 1'b1;
      cfg_factor = f;
      @(negedge clk);
      cfg_we     = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      miss_valid = 1'b0;
      irq_ack = 1'b0;
      cfg_we = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      #(64'd200000 * 20);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog: got %0d expected %0d", 0, 1);
         $display("[TB] %0d tests run, %0d failed", nchk, nfail);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      do_reset();
      chk(irq == 1'b0, "R1", "irq after reset", irq, 0);
      chk(irq_page == '0, "R1", "page after reset", irq_page, 0);

      // R10/R1: default factor 4 -> threshold 256
      do_miss(20'h000A1, 255);
      chk(irq == 1'b0, "R10", "irq below default threshold", irq, 0);
      expect_report(20'h000A1, "R10");
      do_miss(20'h000A1, 1);
      chk(irq == 1'b1, "R3", "irq at default threshold", irq, 1);
      do_ack();

      // R10: factor 1 -> threshold 64
      set_factor(3'd1);
      do_miss(20'h000B2, 63);
      chk(irq == 1'b0, "R3", "irq one below threshold", irq, 0);
      expect_report(20'h000B2, "R3");
      do_miss(20'h000B2, 1);
      chk(irq == 1'b1, "R3", "irq at threshold", irq, 1);
      do_ack();

      // R2: two pages at 40 each do not combine
      do_miss(20'h000C3, 40);
      do_miss(20'h000D4, 40);
      chk(irq == 1'b0, "R2", "separate counts", irq, 0);

      // R4: report holds
      expect_report(20'h000C3, "R4");
      do_miss(20'h000C3, 24);
      repeat (5) @(negedge clk);
      chk(irq == 1'b1, "R4", "irq held", irq, 1);
      chk(irq_page == 20'h000C3, "R4", "page held", irq_page, 20'h000C3);

      // R6: D crosses while C pending
      do_miss(20'h000D4, 30);
      chk(irq_page == 20'h000C3, "R6", "pending page kept", irq_page, 20'h000C3);
      do_ack();
      chk(irq == 1'b0, "R5", "irq cleared by ack", irq, 0);
      expect_report(20'h000D4, "R6");
      do_miss(20'h000D4, 1);
      chk(irq_page == 20'h000D4, "R6", "masked page reported", irq_page, 20'h000D4);
      do_ack();

      // R5: C counter was cleared by its ack
      do_miss(20'h000C3, 63);
      chk(irq == 1'b0, "R5", "cleared counter", irq, 0);
      expect_report(20'h000C3, "R5");
      do_miss(20'h000C3, 1);

      // R9: ack together with a miss on the flagged page
      ack_with_miss(20'h000C3);
      chk(irq == 1'b0, "R9", "ack wins over flagged-page miss", irq, 0);
      do_miss(20'h000C3, 62);
      chk(irq == 1'b0, "R9", "count restarted at 1", irq, 0);
      expect_report(20'h000C3, "R9");
      do_miss(20'h000C3, 1);

      // R9: ack together with a crossing miss on another page
      do_miss(20'h000E5, 70);
      chk(irq_page == 20'h000C3, "R6", "E masked", irq_page, 20'h000C3);
      expect_report(20'h000E5, "R9");
      ack_with_miss(20'h000E5);
      chk(irq == 1'b1, "R9", "irq kept on handover", irq, 1);
      chk(irq_page == 20'h000E5, "R9", "page handed over", irq_page, 20'h000E5);

      // R7: 1034 misses would wrap to 10 with a 10-bit counter
      do_miss(20'h000F6, 1034);
      chk(irq_page == 20'h000E5, "R7", "F masked", irq_page, 20'h000E5);
      do_ack();
      chk(irq == 1'b0, "R5", "irq cleared", irq, 0);
      expect_report(20'h000F6, "R7");
      do_miss(20'h000F6, 1);
      chk(irq == 1'b1, "R7", "saturated count reports", irq, 1);
      do_ack();

      // R8: replacement
      do_reset();
      chk(irq == 1'b0, "R1", "irq after second reset", irq, 0);
      set_factor(3'd1);
      for (int i = 0; i < 16; i++) begin
         do_miss(20'h00100 + 20'(i), (i == 7) ? 2 : 3);
      end
      do_miss(20'h00200, 1);          // evicts page 0x107 (count 2)
      do_miss(20'h00107, 62);         // re-allocated, evicts 0x200 (count 1)
      chk(irq == 1'b0, "R8", "evicted page restarted", irq, 0);
      expect_report(20'h00107, "R8");
      do_miss(20'h00107, 2);
      chk(irq_page == 20'h00107, "R8", "restarted page reported", irq_page, 20'h00107);
      do_ack();
      do_miss(20'h00103, 60);
      chk(irq == 1'b0, "R8", "kept page below threshold", irq, 0);
      expect_report(20'h00103, "R8");
      do_miss(20'h00103, 1);
      chk(irq_page == 20'h00103, "R8", "kept page reported", irq_page, 20'h00103);
      do_ack();

      repeat (3) @(negedge clk);
      chk(exp_q.size() == 0, "R3", "missing reports", exp_q.size(), 0);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
   end
endmodule